// File: doc/BRIEF.md
# Multi-Source ADC Register Controller

This block sits between a byte-wide register bus and a 12-bit analog-to-digital converter. It owns the channel-select and gain-select settings that go to the converter, and it decides when a conversion begins. A start can come from one of three places: a software write to a dedicated offset, an internal pacer made of two chained down-counters, or an external trigger pin that is first synchronized. It latches each finished result into two byte registers. The upper one also carries an active-low data-ready flag, and an optional interrupt fires at the end of every conversion.

The converter is reached through a plain handshake. The controller emits a one-cycle `conv_start` and holds itself busy. The converter later raises `conv_done` for one cycle while presenting its result. Software either polls the data-ready flag or enables the interrupt, then reads the low result byte followed by the high result byte. The read of the high byte re-arms the flag and releases the interrupt.

Top module: `adc_regctl`

## Requirements
- R1: After reset the high result byte (offset 5) reads 0x10, the low result byte (offset 4) reads 0x00, `irq` is 0 and `conv_start` is 0.
- R2: Offset 4 returns result bits 7:0. Offset 5 returns result bits 11:8 in bits 3:0, and its bits 7:5 read 0.
- R3: Bit 4 of offset 5 is the ready flag, where 0 means fresh data. It goes to 1 when a conversion is accepted, goes to 0 on `conv_done`, and returns to 1 after any bus read of offset 5.
- R4: Writing offset 10 sets `conv_chan` from bits 3:0. Reading offset 10 returns the channel that was selected when the most recently completed conversion started, not the current selection.
- R5: Writing offset 9 sets `conv_gain` from bits 2:0. Reading offset 9 returns that 3-bit value with the upper bits zero.
- R6: Offset 11 holds the start-source field in bits 1:0 (0 none, 1 software, 2 pacer, 3 external) and the interrupt enable in bit 4. It reads back with all other bits zero.
- R7: With source 1, a write of any value to offset 12 produces a `conv_start` pulse in the cycle after the write edge. With any other source, such writes produce no start.
- R8: Pacer divisors A (offsets 0 low, 1 high) and B (offsets 2 low, 3 high) are 16-bit values. A low-byte write is only staged, and the value takes effect when the high byte is written. With source 2, starts occur every A×B cycles, and a divisor of 0 acts as 1.
- R9: With source 3, each rising edge of `ext_trig` starts exactly one conversion, after a two-flop synchronizer. A held high level gives no further starts. With any other source the pin is ignored.
- R10: Any start request that arrives while a conversion is in progress (from acceptance until `conv_done`) is dropped.
- R11: When the interrupt enable is 1, `conv_done` sets `irq`. `irq` then stays 1 until a bus read of offset 5. When the enable is 0, `irq` stays 0.
- R12: `conv_start` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; triggers read side effects |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| ext_trig | input | 1 | External start pin, asynchronous |
| conv_start | output | 1 | One-cycle conversion start to converter |
| conv_chan | output | 4 | Selected input channel |
| conv_gain | output | 3 | Selected gain code |
| conv_done | input | 1 | One-cycle end-of-conversion from converter |
| conv_result | input | 12 | Converter result, valid with `conv_done` |
| irq | output | 1 | End-of-conversion interrupt request |

## Verification
The bench sweeps channel and gain codes through software-started conversions and checks how each result splits across the two bytes. A wrong split or a missing mask would put stray bits above bit 3 of the high byte. It also changes the channel after a conversion and expects the readback to stay on the completed one, which catches a design that reports the live selection. The pacer period is measured for every pair of small divisors, plus a wide divisor that needs its high byte. A pacer that counts one cycle too many or too few, or a staged low byte that takes effect early, shows up as a wrong interval. Held external levels, starts issued while busy, and starts issued in the wrong mode must each add exactly the expected number of conversions. A design that triggers on level or does not block while busy would over-count.

// File: rtl/adc_regctl_pkg.sv
package adc_regctl_pkg;

   typedef enum logic [1:0] {
      TRG_OFF  = 2'd0,
      TRG_SOFT = 2'd1,
      TRG_PACE = 2'd2,
      TRG_EXT  = 2'd3
   } trig_mode_e;

   localparam logic [3:0] OFS_DIV_BASE = 4'd0;
   localparam logic [3:0] OFS_RES_LO   = 4'd4;
   localparam logic [3:0] OFS_RES_HI   = 4'd5;
   localparam logic [3:0] OFS_GAIN     = 4'd9;
   localparam logic [3:0] OFS_CHAN     = 4'd10;
   localparam logic [3:0] OFS_CTRL     = 4'd11;
   localparam logic [3:0] OFS_SWSTART  = 4'd12;

   localparam int RDY_BIT   = 4;
   localparam int IRQEN_BIT = 4;

endpackage

// File: rtl/adc_divcnt.sv
module adc_divcnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         step,
   input  logic [W-1:0] div,
   output logic         tick
);

   logic [W-1:0] cnt_q;
   logic         at_end;

   assign at_end = (cnt_q <= W'(1));
   assign tick   = run & step & at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run) begin
         cnt_q <= div;
      end else if (step) begin
         cnt_q <= at_end ? div : cnt_q - W'(1);
      end
   end

endmodule

// File: rtl/adc_pacer.sv
module adc_pacer #(
   parameter int DIV_W  = 16,
   parameter int STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    run,
   input  logic [STAGES*DIV_W-1:0] div_flat,
   output logic                    pace
);

   logic [STAGES:0] step;

   assign step[0] = 1'b1;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      adc_divcnt #(.W(DIV_W)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .run   (run),
         .step  (step[g]),
         .div   (div_flat[g*DIV_W +: DIV_W]),
         .tick  (step[g+1])
      );
   end

   assign pace = step[STAGES];

endmodule

// File: rtl/adc_trigsel.sv
module adc_trigsel
   import adc_regctl_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  trig_mode_e mode,
   input  logic       sw_hit,
   input  logic       pace,
   input  logic       ext_in,
   output logic       req
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   ext_prev_q;
   logic                   ext_rise;

   if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= ext_in;
      end
   end else begin : g_sync_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= {sync_q[SYNC_STAGES-2:0], ext_in};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ext_prev_q <= 1'b0;
      else        ext_prev_q <= sync_q[SYNC_STAGES-1];
   end

   assign ext_rise = sync_q[SYNC_STAGES-1] & ~ext_prev_q;

   always_comb begin
      unique case (mode)
         TRG_SOFT: req = sw_hit;
         TRG_PACE: req = pace;
         TRG_EXT:  req = ext_rise;
         default:  req = 1'b0;
      endcase
   end

endmodule

// File: rtl/adc_result.sv
module adc_result #(
   parameter int DATA_W = 12,
   parameter int CHAN_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [CHAN_W-1:0] chan_sel,
   input  logic              conv_done,
   input  logic [DATA_W-1:0] conv_result,
   input  logic              irq_en,
   input  logic              hi_read,
   output logic [DATA_W-1:0] res_q,
   output logic [CHAN_W-1:0] chan_q,
   output logic              rdy_n,
   output logic              irq
);

   logic [CHAN_W-1:0] pend_chan_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q       <= '0;
         chan_q      <= '0;
         pend_chan_q <= '0;
         rdy_n       <= 1'b1;
      end else begin
         if (accept) pend_chan_q <= chan_sel;
         if (conv_done) begin
            res_q  <= conv_result;
            chan_q <= pend_chan_q;
            rdy_n  <= 1'b0;
         end else if (accept || hi_read) begin
            rdy_n  <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   irq <= 1'b0;
      else if (conv_done && irq_en) irq <= 1'b1;
      else if (hi_read)             irq <= 1'b0;
   end

endmodule

// File: rtl/adc_regctl.sv
module adc_regctl
   import adc_regctl_pkg::*;
#(
   parameter int DATA_W      = 12,
   parameter int CHAN_W      = 4,
   parameter int GAIN_W      = 3,
   parameter int DIV_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              ext_trig,
   output logic              conv_start,
   output logic [CHAN_W-1:0] conv_chan,
   output logic [GAIN_W-1:0] conv_gain,
   input  logic              conv_done,
   input  logic [DATA_W-1:0] conv_result,
   output logic              irq
);

   localparam int HI_BITS     = DATA_W - 8;
   localparam int DIV_HI_W    = DIV_W - 8;
   localparam int PACE_STAGES = 2;

   initial begin
      if (DATA_W < 9 || DATA_W > 12) $fatal(1, "DATA_W must be 9..12");
      if (DIV_W < 9 || DIV_W > 16)   $fatal(1, "DIV_W must be 9..16");
      if (CHAN_W < 1 || CHAN_W > 8)  $fatal(1, "CHAN_W must be 1..8");
      if (GAIN_W < 1 || GAIN_W > 8)  $fatal(1, "GAIN_W must be 1..8");
      if (SYNC_STAGES < 1)           $fatal(1, "SYNC_STAGES must be >= 1");
      if (ADDR_W < 4)                $fatal(1, "ADDR_W must be >= 4");
   end

   function automatic logic at_ofs(input logic [ADDR_W-1:0] a, input logic [3:0] ofs);
      return a == ADDR_W'(ofs);
   endfunction

   // ---------------- programmable state ----------------
   logic [GAIN_W-1:0] gain_q;
   logic [CHAN_W-1:0] chan_sel_q;
   trig_mode_e        mode_q;
   logic              irq_en_q;
   logic [7:0]        div_stage_q [PACE_STAGES];
   logic [DIV_W-1:0]  div_q       [PACE_STAGES];
   logic [PACE_STAGES*DIV_W-1:0] div_flat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gain_q     <= '0;
         chan_sel_q <= '0;
         mode_q     <= TRG_OFF;
         irq_en_q   <= 1'b0;
         for (int k = 0; k < PACE_STAGES; k++) begin
            div_stage_q[k] <= '0;
            div_q[k]       <= '0;
         end
      end else if (bus_wr) begin
         if (at_ofs(bus_addr, OFS_GAIN)) gain_q     <= bus_wdata[GAIN_W-1:0];
         if (at_ofs(bus_addr, OFS_CHAN)) chan_sel_q <= bus_wdata[CHAN_W-1:0];
         if (at_ofs(bus_addr, OFS_CTRL)) begin
            mode_q   <= trig_mode_e'(bus_wdata[1:0]);
            irq_en_q <= bus_wdata[IRQEN_BIT];
         end
         for (int k = 0; k < PACE_STAGES; k++) begin
            if (at_ofs(bus_addr, OFS_DIV_BASE + 4'(2*k)))
               div_stage_q[k] <= bus_wdata;
            if (at_ofs(bus_addr, OFS_DIV_BASE + 4'(2*k+1)))
               div_q[k] <= {bus_wdata[DIV_HI_W-1:0], div_stage_q[k]};
         end
      end
   end

   for (genvar g = 0; g < PACE_STAGES; g++) begin : g_divflat
      assign div_flat[g*DIV_W +: DIV_W] = div_q[g];
   end

   // ---------------- start path ----------------
   logic pace_tick;
   logic sw_hit;
   logic start_req;
   logic accept;
   logic busy_q;
   logic hi_read;

   assign sw_hit  = bus_wr & at_ofs(bus_addr, OFS_SWSTART);
   assign hi_read = bus_rd & at_ofs(bus_addr, OFS_RES_HI);

   adc_pacer #(.DIV_W(DIV_W), .STAGES(PACE_STAGES)) u_pacer (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (mode_q == TRG_PACE),
      .div_flat (div_flat),
      .pace     (pace_tick)
   );

   adc_trigsel #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode   (mode_q),
      .sw_hit (sw_hit),
      .pace   (pace_tick),
      .ext_in (ext_trig),
      .req    (start_req)
   );

   assign accept = start_req & ~busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         conv_start <= 1'b0;
      end else begin
         conv_start <= accept;
         if (accept)         busy_q <= 1'b1;
         else if (conv_done) busy_q <= 1'b0;
      end
   end

   // ---------------- result capture ----------------
   logic [DATA_W-1:0] res_q;
   logic [CHAN_W-1:0] last_chan_q;
   logic              rdy_n_w;

   adc_result #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_res (
      .clk         (clk),
      .rst_n       (rst_n),
      .accept      (accept),
      .chan_sel    (chan_sel_q),
      .conv_done   (conv_done),
      .conv_result (conv_result),
      .irq_en      (irq_en_q),
      .hi_read     (hi_read),
      .res_q       (res_q),
      .chan_q      (last_chan_q),
      .rdy_n       (rdy_n_w),
      .irq         (irq)
   );

   assign conv_chan = chan_sel_q;
   assign conv_gain = gain_q;

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      if (at_ofs(bus_addr, OFS_RES_LO)) begin
         bus_rdata = res_q[7:0];
      end else if (at_ofs(bus_addr, OFS_RES_HI)) begin
         bus_rdata[HI_BITS-1:0] = res_q[DATA_W-1:8];
         bus_rdata[RDY_BIT]     = rdy_n_w;
      end else if (at_ofs(bus_addr, OFS_GAIN)) begin
         bus_rdata[GAIN_W-1:0] = gain_q;
      end else if (at_ofs(bus_addr, OFS_CHAN)) begin
         bus_rdata[CHAN_W-1:0] = last_chan_q;
      end else if (at_ofs(bus_addr, OFS_CTRL)) begin
         bus_rdata[1:0]       = mode_q;
         bus_rdata[IRQEN_BIT] = irq_en_q;
      end
   end

endmodule

// File: rtl/adc_regctl_chk.sv
module adc_regctl_chk #(
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              conv_start,
   input logic              conv_done,
   input logic              irq,
   input logic              irq_en,
   input logic              rdy_n
);

   logic chk_busy;
   logic hi_rd;

   assign hi_rd = bus_rd && (bus_addr == ADDR_W'(5));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        chk_busy <= 1'b0;
      else if (conv_start && !conv_done) chk_busy <= 1'b1;
      else if (conv_done)                chk_busy <= 1'b0;
   end

   assert_start_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);

   assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> !chk_busy);

   assert_done_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done |=> !rdy_n);

   assert_start_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(conv_start) |-> rdy_n);

   assert_read_rearm_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_rd && !conv_done) |=> rdy_n);

   assert_irq_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && irq_en) |=> irq);

   assert_irq_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_rd && !conv_done) |=> !irq);

   assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq && !(conv_done && irq_en)) |=> !irq);

endmodule

bind adc_regctl adc_regctl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_rd     (bus_rd),
   .bus_addr   (bus_addr),
   .conv_start (conv_start),
   .conv_done  (conv_done),
   .irq        (irq),
   .irq_en     (irq_en_q),
   .rdy_n      (rdy_n_w)
);

// File: tb/adc_regctl_bench.sv
`timescale 1ns/1ps
module adc_regctl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        ext_trig = 1'b0;
   logic        conv_start;
   logic [3:0]  conv_chan;
   logic [2:0]  conv_gain;
   logic        conv_done = 1'b0;
   logic [11:0] conv_result = '0;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   int cyc = 0, nstart = 0, ndone = 0, last_st = 0, prev_st = 0;
   int lat = 0, cnt_c = 0, dbl = 0;
   bit pend = 0, start_prev = 0;

   always #2.5 clk = ~clk;

   adc_regctl u_adc_regctl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_trig(ext_trig),
      .conv_start(conv_start), .conv_chan(conv_chan), .conv_gain(conv_gain),
      .conv_done(conv_done), .conv_result(conv_result), .irq(irq)
   );

   function automatic int res_of(int n);
      return (n * 389 + 77) % 4096;
   endfunction

   // converter model and start monitor
   initial begin
      forever begin
         @(posedge clk);
         #1;
         cyc++;
         conv_done = 1'b0;
         if (conv_start && start_prev) dbl++;
         start_prev = conv_start;
         if (conv_start) begin
            nstart++;
            prev_st = last_st;
            last_st = cyc;
            pend = 1;
            cnt_c = lat;
         end
         if (pend) begin
            if (cnt_c == 0) begin
               conv_result = 12'(res_of(ndone));
               conv_done = 1'b1;
               ndone++;
               pend = 0;
            end else begin
               cnt_c--;
            end
         end
      end
   end

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wait_cyc(int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic bw(int a, int d);
      @(posedge clk); #2;
      bus_addr = 4'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
      @(posedge clk); #2;
      bus_wr = 1'b0;
   endtask

   task automatic br(int a, output int d);
      @(posedge clk); #2;
      bus_addr = 4'(a); bus_rd = 1'b1;
      #1 d = int'(bus_rdata);
      @(posedge clk); #2;
      bus_rd = 1'b0;
   endtask

   task automatic bp(int a, output int d);
      @(posedge clk); #2;
      bus_addr = 4'(a);
      #1 d = int'(bus_rdata);
   endtask

   task automatic set_div(int a, int b);
      bw(0, a & 255); bw(1, a >> 8);
      bw(2, b & 255); bw(3, b >> 8);
   endtask

   task automatic pace_period(int exp_p, string req);
      int s0, guard;
      s0 = nstart;
      bw(11, 2);
      guard = 0;
      while (nstart < s0 + 3 && guard < 5000) begin
         @(posedge clk); guard++;
      end
      bw(11, 0);
      check(req, last_st - prev_st, exp_p);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int d, s0, ch, g, r;
      wait_cyc(5);
      #1 rst_n = 1'b1;

      // R1 reset state
      bp(5, d); check("R1 hi byte", d, 8'h10);
      bp(4, d); check("R1 lo byte", d, 0);
      check("R1 irq", int'(irq), 0);
      check("R1 conv_start", int'(conv_start), 0);

      // R6 control readback
      bw(11, 8'h13); bp(11, d); check("R6 ctrl", d, 8'h13);
      bw(11, 8'hEE); bp(11, d); check("R6 ctrl mask", d, 8'h02);
      bw(11, 8'h01);

      // R2 R3 R4 R5 R7 sweep of channel and gain
      for (int i = 0; i < 32; i++) begin
         ch = i % 16; g = (i * 3) % 8;
         bw(9, g | 8'hF8); bw(10, ch | 8'hF0);
         check("R5 conv_gain", int'(conv_gain), g);
         check("R4 conv_chan", int'(conv_chan), ch);
         s0 = nstart;
         bw(12, i * 7);
         wait_cyc(4);
         check("R7 sw start", nstart - s0, 1);
         r = res_of(ndone - 1);
         br(4, d); check("R2 lo", d, r & 255);
         br(5, d); check("R2 R3 hi with ready", d, r >> 8);
         bp(5, d); check("R3 rearmed", d, (r >> 8) | 8'h10);
         bw(10, (ch + 1) % 16);
         bp(10, d); check("R4 last chan", d, ch);
         bp(9, d); check("R5 gain read", d, g);
      end

      // R7 ignored in other modes
      bw(11, 0); s0 = nstart; bw(12, 8'h5A); wait_cyc(5);
      check("R7 off ignored", nstart - s0, 0);
      bw(11, 3); s0 = nstart; bw(12, 8'hA5); wait_cyc(5);
      check("R7 ext ignored", nstart - s0, 0);

      // R10 busy drop
      bw(11, 1); lat = 12; s0 = nstart;
      bw(12, 1); wait_cyc(1);
      bp(5, d); check("R3 busy flag", (d >> 4) & 1, 1);
      bw(12, 2); bw(12, 3);
      wait_cyc(20);
      check("R10 dropped", nstart - s0, 1);
      lat = 0;

      // R11 interrupt
      bw(11, 8'h11); bw(12, 0); wait_cyc(4);
      check("R11 irq set", int'(irq), 1);
      bp(5, d); wait_cyc(2);
      check("R11 irq held", int'(irq), 1);
      br(5, d); #1;
      check("R11 irq cleared", int'(irq), 0);
      bw(11, 8'h01); bw(12, 0); wait_cyc(4);
      check("R11 irq disabled", int'(irq), 0);
      br(5, d);

      // R8 pacer sweep
      bw(11, 0);
      for (int a = 1; a <= 4; a++) begin
         for (int b = 1; b <= 4; b++) begin
            if (a * b >= 2) begin
               set_div(a, b);
               pace_period(a * b, "R8 period");
            end
         end
      end
      set_div(0, 3); pace_period(3, "R8 zero divisor");
      set_div(256, 1); pace_period(256, "R8 high byte");
      set_div(3, 2);
      bw(0, 7);
      pace_period(6, "R8 staged low");

      // R9 external trigger
      bw(11, 3); ext_trig = 1'b0; wait_cyc(5);
      s0 = nstart;
      ext_trig = 1'b1; wait_cyc(10);
      check("R9 rise", nstart - s0, 1);
      wait_cyc(20);
      check("R9 level held", nstart - s0, 1);
      ext_trig = 1'b0; wait_cyc(5);
      ext_trig = 1'b1; wait_cyc(10);
      check("R9 second rise", nstart - s0, 2);
      ext_trig = 1'b0;
      bw(11, 1); wait_cyc(5);
      s0 = nstart;
      ext_trig = 1'b1; wait_cyc(10); ext_trig = 1'b0;
      check("R9 ignored sw mode", nstart - s0, 0);

      // R12 pulse width
      check("R12 single pulse", dbl, 0);

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule